// File: doc/BRIEF.md
# Clock Mode Decoder and Ratio Divider

This block turns a three-bit frequency select into a clocking mode and derives the processor, bus, interrupt-controller, reference and serial-bus clocks from a fast synthesized source. Each output has its own drive-enable bit, so a pad ring can tri-state it. With the defaults, a 200 MHz synthesized clock gives a 100 MHz processor clock (divide by 2) or a 66.67 MHz one (divide by 3). The bus clock is 33.33 MHz (divide by 6) in both cases, so the processor-to-bus ratio is 3 or 2.

The select code is taken only while reset is held and is then frozen until the next reset. One code switches every output off. Another is a test mode that replaces the synthesized source with the clock on the crystal input and divides it by fixed ratios. The four codes with mismatched select bits are reserved: the processor and bus clocks are parked low there, while the reference and serial-bus clocks keep running. All divider lanes leave reset together, so rising edges of the processor and bus clocks coincide. A build option takes the interrupt-controller clock from half the bus clock instead of from the reference clock.

Top module: `clk_ratio_gen`

## Requirements
- R1: Select code 000 (sel_100, sel_1, sel_0) clears all five bits of out_en and holds every clock output low.
- R2: Code 111 gives cpu_clk = pll_clk/2 and pci_clk = pll_clk/6, both at 50 % duty, with ref_out following ref_clk and usb_out following usb_clk.
- R3: Code 011 gives cpu_clk = pll_clk/3 at 50 % duty, using both edges of the source, and pci_clk = pll_clk/6.
- R4: Code 100 is test mode: ref_clk drives the dividers, giving cpu_clk = ref_clk/2, pci_clk = ref_clk/6, usb_out = ref_clk/2 and ref_out = ref_clk.
- R5: Codes 001, 010, 101 and 110 hold cpu_clk and pci_clk low with their enables still set and raise rsvd_mode. ref_out and usb_out keep running. rsvd_mode is low in every other code.
- R6: With APIC_FROM_PCI = 1, apic_clk is pci_clk/2: pll_clk/12 in codes 011 and 111, ref_clk/12 in code 100, and held low in reserved codes.
- R7: The select inputs are sampled only while rst_n is low. Changing them after reset is released has no effect on the mode or the outputs.
- R8: During reset every divided clock is low. On leaving reset, the first rising edges of cpu_clk and pci_clk fall on the same source edge.
- R9: out_en bit order is {usb, ref, apic, pci, cpu} (bit 0 = cpu). Every non-000 code sets all five bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pll_clk | input | 1 | Synthesized source clock (200 MHz nominal) |
| ref_clk | input | 1 | Crystal clock; carries the test clock in test mode |
| usb_clk | input | 1 | 48 MHz synthesized serial-bus clock |
| rst_n | input | 1 | Synchronous active-low reset; selects are latched while low |
| sel_100 | input | 1 | Select bit 2: high picks the fast processor rate |
| sel_1 | input | 1 | Select bit 1 |
| sel_0 | input | 1 | Select bit 0 |
| cpu_clk | output | 1 | Processor clock |
| pci_clk | output | 1 | Bus clock |
| apic_clk | output | 1 | Interrupt-controller clock |
| ref_out | output | 1 | Buffered reference clock |
| usb_out | output | 1 | Serial-bus clock |
| out_en | output | 5 | Per-output drive enables, bit order {usb, ref, apic, pci, cpu} |
| rsvd_mode | output | 1 | High while a reserved select code is latched |

## Verification
The assertions assume that rst_n stays low across at least one ref_clk edge and one edge of the divider source clock, so the mode register and every lane start from a known state. They also assume that pll_clk keeps running in every mode, because the output-state checks are clocked by it. The stimulus changes the selects only while reset is held, apart from the one deliberate change after release that tests R7. It holds reset for 300 ns and releases it at an instant that coincides with no edge of any input clock. Period and high-time measurements then show that the active-edge relations the assertions rely on actually appear at the pins.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
// Package: mode encoding and select decoding shared by the clock generator.
// Assumes the three select bits are presented as {sel_100, sel_1, sel_0}.
package clkgen_pkg;

    typedef enum logic [2:0] {
        MODE_OFF  = 3'd0,
        MODE_TEST = 3'd1,
        MODE_SLOW = 3'd2,
        MODE_FAST = 3'd3,
        MODE_RSVD = 3'd4
    } clk_mode_e;

    // Output enable bit positions
    localparam int OE_CPU  = 0;
    localparam int OE_PCI  = 1;
    localparam int OE_APIC = 2;
    localparam int OE_REF  = 3;
    localparam int OE_USB  = 4;
    localparam int OE_W    = 5;

    // Map a raw select code onto a clocking mode
    function automatic clk_mode_e decode_sel(input logic [2:0] code);
        case (code)
            3'b000:  return MODE_OFF;
            3'b100:  return MODE_TEST;
            3'b011:  return MODE_SLOW;
            3'b111:  return MODE_FAST;
            default: return MODE_RSVD;
        endcase
    endfunction

endpackage

// File: rtl/clk_mode_latch.sv
`timescale 1ns/1ps
// Module: clk_mode_latch
// Captures the decoded select code on ref_clk while rst_n is low and holds it
// afterwards. Assumes ref_clk toggles at least once while reset is asserted.
module clk_mode_latch
    import clkgen_pkg::*;
(
    input  logic      ref_clk,
    input  logic      rst_n,
    input  logic      sel_100,
    input  logic      sel_1,
    input  logic      sel_0,
    output clk_mode_e mode
);

    clk_mode_e mode_q;

    // Load the mode only during reset; hold it otherwise
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            mode_q <= decode_sel({sel_100, sel_1, sel_0});
        end
    end

    assign mode = mode_q;

    // R7: once reset is released the latched mode never moves
    assert_mode_frozen_R7: assert property (
        @(posedge ref_clk) disable iff (!rst_n) $stable(mode_q)
    );

endmodule

// File: rtl/clk_div_lane.sv
`timescale 1ns/1ps
// Module: clk_div_lane
// Divides clk by a run-time ratio 'div' (>= 2) at 50 % duty. Odd ratios
// stretch the high phase by half a source period with a falling-edge flop.
// Assumes div is stable while rst_n is high; the lane restarts on reset so
// that all lanes sharing clk produce their first rising edge together.
module clk_div_lane #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div,
    output logic         clk_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;
    logic [W-1:0] half;
    logic         hi_q;
    logic         hn_q;

    assign half = div >> 1;

    // Next count value, wrapping at div-1
    always_comb begin
        cnt_nxt = (cnt_q == div - 1'b1) ? '0 : cnt_q + 1'b1;
    end

    // Rising-edge counter and high phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= div - 1'b1;
            hi_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            hi_q  <= (cnt_nxt < half);
        end
    end

    // Half-cycle extension used only for odd ratios
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            hn_q <= 1'b0;
        end else begin
            hn_q <= hi_q & div[0];
        end
    end

    assign clk_o = hi_q | hn_q;

    // R8: every rising edge of the high phase starts at count zero
    assert_rise_at_wrap_R8: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(hi_q) |-> (cnt_q == '0)
    );

    // R2: even ratios never use the falling-edge extension
    assert_even_single_edge_R2: assert property (
        @(negedge clk) disable iff (!rst_n) !div[0] |=> !hn_q
    );

endmodule

// File: rtl/clk_ratio_gen.sv
`timescale 1ns/1ps
// Module: clk_ratio_gen (top)
// Decodes the frequency select at reset, picks the divider source (synthesized
// clock, or ref_clk in test mode) and builds the processor, bus and
// interrupt-controller clocks from lanes that share one reset. Assumes
// pll_clk runs in every mode and that the selects settle during reset.
module clk_ratio_gen
    import clkgen_pkg::*;
#(
    parameter int CPU_DIV_FAST  = 2,
    parameter int CPU_DIV_SLOW  = 3,
    parameter int PCI_DIV       = 6,
    parameter bit APIC_FROM_PCI = 1'b1
) (
    input  logic            pll_clk,
    input  logic            ref_clk,
    input  logic            usb_clk,
    input  logic            rst_n,
    input  logic            sel_100,
    input  logic            sel_1,
    input  logic            sel_0,
    output logic            cpu_clk,
    output logic            pci_clk,
    output logic            apic_clk,
    output logic            ref_out,
    output logic            usb_out,
    output logic [OE_W-1:0] out_en,
    output logic            rsvd_mode
);

    localparam int APIC_DIV = 2 * PCI_DIV;
    localparam int DIV_W    = $clog2(APIC_DIV + 1);

    clk_mode_e  mode;
    logic       div_clk;
    logic [DIV_W-1:0] cpu_div;
    logic       lane_cpu;
    logic       lane_pci;
    logic       apic_src;

    clk_mode_latch u_latch (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .sel_100 (sel_100),
        .sel_1   (sel_1),
        .sel_0   (sel_0),
        .mode    (mode)
    );

    // Divider source: test clock replaces the synthesized clock in test mode
    assign div_clk = (mode == MODE_TEST) ? ref_clk : pll_clk;

    // Processor ratio depends on the fast/slow select
    assign cpu_div = (mode == MODE_SLOW) ? DIV_W'(CPU_DIV_SLOW) : DIV_W'(CPU_DIV_FAST);

    clk_div_lane #(.W(DIV_W)) u_cpu_lane (
        .clk   (div_clk),
        .rst_n (rst_n),
        .div   (cpu_div),
        .clk_o (lane_cpu)
    );

    clk_div_lane #(.W(DIV_W)) u_pci_lane (
        .clk   (div_clk),
        .rst_n (rst_n),
        .div   (DIV_W'(PCI_DIV)),
        .clk_o (lane_pci)
    );

    // Interrupt-controller source: half the bus clock or the reference clock
    generate
        if (APIC_FROM_PCI) begin : g_apic_pci
            clk_div_lane #(.W(DIV_W)) u_apic_lane (
                .clk   (div_clk),
                .rst_n (rst_n),
                .div   (DIV_W'(APIC_DIV)),
                .clk_o (apic_src)
            );
        end else begin : g_apic_ref
            assign apic_src = ref_clk;
        end
    endgenerate

    // Output steering and enables per mode
    always_comb begin
        out_en   = '1;
        cpu_clk  = lane_cpu;
        pci_clk  = lane_pci;
        apic_clk = apic_src;
        ref_out  = ref_clk;
        usb_out  = usb_clk;
        case (mode)
            MODE_OFF: begin
                out_en   = '0;
                cpu_clk  = 1'b0;
                pci_clk  = 1'b0;
                apic_clk = 1'b0;
                ref_out  = 1'b0;
                usb_out  = 1'b0;
            end
            MODE_TEST: begin
                usb_out = lane_cpu;
            end
            MODE_RSVD: begin
                cpu_clk = 1'b0;
                pci_clk = 1'b0;
                if (APIC_FROM_PCI) begin
                    apic_clk = 1'b0;
                end
            end
            default: begin
            end
        endcase
    end

    assign rsvd_mode = (mode == MODE_RSVD);

    // R1: the all-off code leaves every pin undriven and low
    assert_off_quiet_R1: assert property (
        @(posedge pll_clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> (out_en == '0 && !cpu_clk && !pci_clk && !ref_out && !usb_out)
    );

    // R5: reserved codes park the processor and bus clocks while driving them
    assert_rsvd_parked_R5: assert property (
        @(posedge pll_clk) disable iff (!rst_n)
        rsvd_mode |-> (!cpu_clk && !pci_clk && out_en[OE_CPU] && out_en[OE_PCI])
    );

    // R9: any code other than all-off enables every output
    assert_enables_on_R9: assert property (
        @(posedge pll_clk) disable iff (!rst_n)
        (mode != MODE_OFF) |-> (out_en == '1)
    );

endmodule

// File: tb/tb_clk_ratio_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected waveform items, a monitor
// pops each one and measures the selected output in 0.25 ns steps.
module tb_clk_ratio_gen;

    typedef struct {
        int idx;   // 0 cpu, 1 pci, 2 apic, 3 ref, 4 usb
        int kind;  // 0 period/high, 1 stays low, 2 cpu/pci rising alignment
        int per;   // expected period in 0.25 ns steps
        int hi;    // expected high time in 0.25 ns steps
    } item_t;

    logic pll_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic usb_clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_100 = 1'b0;
    logic sel_1 = 1'b0;
    logic sel_0 = 1'b0;
    logic cpu_clk, pci_clk, apic_clk, ref_out, usb_out, rsvd_mode;
    logic [4:0] out_en;
    logic [4:0] outs;

    realtime ref_half = 35.0;
    int checks = 0;
    int errors = 0;
    bit mon_busy = 1'b0;
    item_t q[$];
    string rq[$];

    clk_ratio_gen dut (
        .pll_clk   (pll_clk),
        .ref_clk   (ref_clk),
        .usb_clk   (usb_clk),
        .rst_n     (rst_n),
        .sel_100   (sel_100),
        .sel_1     (sel_1),
        .sel_0     (sel_0),
        .cpu_clk   (cpu_clk),
        .pci_clk   (pci_clk),
        .apic_clk  (apic_clk),
        .ref_out   (ref_out),
        .usb_out   (usb_out),
        .out_en    (out_en),
        .rsvd_mode (rsvd_mode)
    );

    assign outs = {usb_out, ref_out, apic_clk, pci_clk, cpu_clk};

    always #2.5 pll_clk = ~pll_clk;
    always #10 usb_clk = ~usb_clk;
    always #(ref_half) ref_clk = ~ref_clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_clk(input string req, input int idx, input int kind,
                              input int per, input int hi);
        item_t it;
        it.idx = idx; it.kind = kind; it.per = per; it.hi = hi;
        rq.push_back(req);
        q.push_back(it);
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || mon_busy) #1;
    endtask

    // Monitor: measure each queued item at the outputs
    initial begin
        #0.1;
        forever begin
            item_t it;
            string req;
            int n, t0, t1, t2;
            bit pp, cp, found, ok;
            while (q.size() == 0) #0.25;
            mon_busy = 1'b1;
            it = q.pop_front();
            req = rq.pop_front();
            n = 0;
            if (it.kind == 0) begin
                while (outs[it.idx] && n < 4000) begin #0.25; n++; end
                while (!outs[it.idx] && n < 4000) begin #0.25; n++; end
                t0 = n;
                while (outs[it.idx] && n < 4000) begin #0.25; n++; end
                t1 = n;
                while (!outs[it.idx] && n < 4000) begin #0.25; n++; end
                t2 = n;
                if (n >= 4000) chk({req, " edge timeout"}, n, 0);
                else begin
                    chk({req, " period"}, t2 - t0, it.per);
                    chk({req, " high time"}, t1 - t0, it.hi);
                end
            end else if (it.kind == 1) begin
                found = 1'b0;
                for (int k = 0; k < 400; k++) begin
                    #0.25;
                    if (outs[it.idx]) found = 1'b1;
                end
                chk({req, " stays low"}, int'(found), 0);
            end else begin
                pp = outs[1]; cp = outs[0]; found = 1'b0; ok = 1'b0;
                while (n < 4000 && !found) begin
                    #0.25; n++;
                    if (outs[1] && !pp) begin
                        found = 1'b1;
                        ok = outs[0] && !cp;
                    end
                    pp = outs[1]; cp = outs[0];
                end
                chk({req, " cpu/pci first rise aligned"}, int'(ok), 1);
            end
            mon_busy = 1'b0;
        end
    end

    // Hold reset with a code applied; optionally check alignment at release
    task automatic apply_code(input logic [2:0] code, input bit test, input bit align);
        rst_n = 1'b0;
        {sel_100, sel_1, sel_0} = code;
        ref_half = test ? 4.0 : 35.0;
        #300;
        @(negedge pll_clk);
        #1;
        if (align) begin
            expect_clk("R8", 0, 2, 0, 0);
            while (!mon_busy) #0.25;
        end
        rst_n = 1'b1;
        wait_idle();
    endtask

    // Driver
    initial begin
        // R8: divided clocks low during reset
        rst_n = 1'b0;
        {sel_100, sel_1, sel_0} = 3'b111;
        #300;
        chk("R8 reset cpu low", int'(cpu_clk), 0);
        chk("R8 reset pci low", int'(pci_clk), 0);
        chk("R8 reset apic low", int'(apic_clk), 0);

        // Fast code 111
        apply_code(3'b111, 1'b0, 1'b1);
        chk("R9 enables fast", int'(out_en), 31);
        chk("R5 rsvd low fast", int'(rsvd_mode), 0);
        expect_clk("R2 cpu /2", 0, 0, 40, 20);
        expect_clk("R2 pci /6", 1, 0, 120, 60);
        expect_clk("R6 apic pci/2 fast", 2, 0, 240, 120);
        expect_clk("R2 ref follows", 3, 0, 280, 140);
        expect_clk("R2 usb follows", 4, 0, 80, 40);
        wait_idle();

        // Slow code 011
        apply_code(3'b011, 1'b0, 1'b1);
        chk("R9 enables slow", int'(out_en), 31);
        expect_clk("R3 cpu /3 duty", 0, 0, 60, 30);
        expect_clk("R3 pci /6", 1, 0, 120, 60);
        expect_clk("R6 apic pci/2 slow", 2, 0, 240, 120);
        wait_idle();

        // R7: select change after release is ignored
        {sel_100, sel_1, sel_0} = 3'b000;
        #100;
        chk("R7 enables kept", int'(out_en), 31);
        expect_clk("R7 cpu still /3", 0, 0, 60, 30);
        expect_clk("R7 pci still /6", 1, 0, 120, 60);
        wait_idle();

        // Off code 000
        apply_code(3'b000, 1'b0, 1'b0);
        #50;
        chk("R1 enables cleared", int'(out_en), 0);
        chk("R1 outputs low", int'(outs), 0);
        chk("R5 rsvd low off", int'(rsvd_mode), 0);
        expect_clk("R1 cpu", 0, 1, 0, 0);
        expect_clk("R1 ref", 3, 1, 0, 0);
        expect_clk("R1 usb", 4, 1, 0, 0);
        wait_idle();

        // Test code 100 with an 8 ns test clock
        apply_code(3'b100, 1'b1, 1'b1);
        chk("R9 enables test", int'(out_en), 31);
        expect_clk("R4 cpu tclk/2", 0, 0, 64, 32);
        expect_clk("R4 pci tclk/6", 1, 0, 192, 96);
        expect_clk("R6 apic tclk/12", 2, 0, 384, 192);
        expect_clk("R4 ref = tclk", 3, 0, 32, 16);
        expect_clk("R4 usb tclk/2", 4, 0, 64, 32);
        wait_idle();

        // Reserved codes
        for (int c = 1; c < 7; c++) begin
            if (c == 3 || c == 4) continue;
            apply_code(3'(c), 1'b0, 1'b0);
            chk("R5 rsvd flag", int'(rsvd_mode), 1);
            chk("R5 enables on", int'(out_en), 31);
            expect_clk("R5 cpu parked", 0, 1, 0, 0);
            expect_clk("R5 pci parked", 1, 1, 0, 0);
            expect_clk("R6 apic parked", 2, 1, 0, 0);
            expect_clk("R5 ref runs", 3, 0, 280, 140);
            expect_clk("R5 usb runs", 4, 0, 80, 40);
            wait_idle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule